// File: doc/BRIEF.md
# Page-Committed Summary FIFO

This block queues short records that a producer assembles one page at a time and a consumer drains one word at a time. The store holds a parameterized number of pages (32 by default), and each page is eight 32-bit words. The producer writes words in any order and at any time into a private open page, addressing each word by its offset. It then issues a commit, which moves the whole page into the queue in one cycle and clears the open page for the next record. Nothing from an open page is visible to the consumer before the commit.

The consumer side is a plain word FIFO with a request/strobe handshake, which suits a DMA engine. A request line is high whenever at least one committed word is waiting. Each strobe takes the word on the read data port and moves to the next word. Words of a page come out in offset order 0 to 7, and pages come out in commit order.

Empty and full levels are brought out on pins. A small interrupt register records three events: the queue becoming empty, the queue becoming full, and a pulse on an external overflow input. Each event has its own mask bit. An event is latched only while its mask bit is set, and a latched bit is cleared by writing a 1 to it.

Top module: `spf_top`

## Requirements
- R1: After reset the queue is empty (`fifo_empty`=1, `fifo_full`=0, `data_req`=0), the open page holds all zeros, and `irq_reg` and `irq` are 0.
- R2: After a commit, the eight words of that page are read out in offset order 0,1,...,7. The word presented at read number k is the last value written at offset k before the commit. A write in the same cycle as a commit is part of the committed page.
- R3: Writes to the open page do not change `fifo_empty` or `data_req` until a commit. A commit accepted while the queue is not full makes `data_req` 1 from the next cycle.
- R4: A second write to an offset of the open page replaces the first one.
- R5: An accepted commit clears the open page, so offsets that are not written before the next commit read out as 0.
- R6: `data_req` is 1 exactly when `fifo_empty` is 0. A `rd_strobe` pops one word when data is present and has no effect on an empty queue.
- R7: `fifo_full` is 1 when all pages hold committed data. A commit while full is dropped, and the open page keeps its contents for a later commit.
- R8: A page frees its slot only when its eighth word is popped, so `fifo_full` stays 1 through the first seven pops of the oldest page.
- R9: `irq_reg` bit 0 latches when the queue becomes empty, bit 1 when it becomes full, and bit 2 on an `ovf_evt` pulse. Each latches only while its mask bit is 1: bit 3 for bit 0, bit 4 for bit 1, bit 5 for bit 2. An event and the latch both take effect at the clock edge after the condition appears.
- R10: A `cfg_wr` loads `cfg_wdata[5:3]` into the mask bits and clears each status bit whose `cfg_wdata` bit (0 to 2) is 1. A 0 in those positions leaves the status bit unchanged.
- R11: `irq` is 1 exactly when any of `irq_reg` bits 0 to 2 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write a word into the open page |
| wr_off | input | 3 | Word offset within the open page |
| wr_data | input | 32 | Word to write |
| commit | input | 1 | Move the open page into the queue |
| rd_strobe | input | 1 | Pop the word on `rd_data` |
| rd_data | output | 32 | Oldest unread word |
| data_req | output | 1 | At least one word is waiting |
| fifo_empty | output | 1 | No committed word is waiting |
| fifo_full | output | 1 | Every page holds committed data |
| ovf_evt | input | 1 | External overflow event pulse |
| cfg_wr | input | 1 | Write to the interrupt register |
| cfg_wdata | input | 6 | Bits 2:0 write-1-to-clear status, bits 5:3 new mask |
| irq_reg | output | 6 | {mask[2:0], status[2:0]} |
| irq | output | 1 | Any status bit is set |

## Verification
Commits, pops and register writes take effect at the edge where they are sampled, so `fifo_empty`, `fifo_full`, `data_req` and the next `rd_data` word are due one edge after the stimulus. An interrupt status bit latches one edge after the empty or full level changes, which is two edges after the commit or pop that caused it. An `ovf_evt` pulse latches one edge after the pulse. The bench drives inputs on the falling edge and samples on the next falling edge after the number of rising edges that each result needs. For the status bits it waits one extra edge before reading them.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam int IRQ_EVENTS = 3;
  localparam int EV_EMPTY   = 0;
  localparam int EV_FULL    = 1;
  localparam int EV_OVF     = 2;
  typedef logic [IRQ_EVENTS-1:0] ev_vec_t;
endpackage

// File: rtl/spf_open_page.sv
module spf_open_page #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int OW   = $clog2(WORDS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [OW-1:0]              wr_off,
  input  logic [DW-1:0]              wr_data,
  input  logic                       clear,
  output logic [WORDS-1:0][DW-1:0]   page_view
);
  logic [WORDS-1:0][DW-1:0] buf_q;

  // merged view: a write in this cycle is already part of the page
  always_comb begin
    page_view = buf_q;
    if (wr_en) page_view[wr_off] = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (clear) begin
      buf_q <= '0;
    end else if (wr_en) begin
      buf_q[wr_off] <= wr_data;
    end
  end
endmodule

// File: rtl/spf_store.sv
module spf_store #(
  parameter int PAGES = 32,
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int PW   = $clog2(PAGES),
  localparam int OW   = $clog2(WORDS),
  localparam int AW   = PW + OW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_page,
  input  logic [WORDS-1:0][DW-1:0] page_in,
  input  logic                     pop_req,
  output logic [DW-1:0]            head_word,
  output logic                     is_empty,
  output logic                     is_full,
  output logic                     pop_done
);
  logic [DW-1:0] mem [PAGES*WORDS];
  logic [PW:0]   wr_pg_q, rd_pg_q;
  logic [OW-1:0] rd_off_q;

  function automatic logic [PW:0] pages_used(input logic [PW:0] wp, input logic [PW:0] rp);
    return wp - rp;
  endfunction

  function automatic logic [AW-1:0] word_addr(input logic [PW:0] pg, input logic [OW-1:0] off);
    return {pg[PW-1:0], off};
  endfunction

  assign is_empty  = (pages_used(wr_pg_q, rd_pg_q) == '0);
  assign is_full   = (pages_used(wr_pg_q, rd_pg_q) == (PW+1)'(PAGES));
  assign pop_done  = pop_req && !is_empty;
  assign head_word = mem[word_addr(rd_pg_q, rd_off_q)];

  always_ff @(posedge clk) begin
    if (push_page) begin
      for (int w = 0; w < WORDS; w++) begin
        mem[word_addr(wr_pg_q, OW'(w))] <= page_in[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_pg_q  <= '0;
      rd_pg_q  <= '0;
      rd_off_q <= '0;
    end else begin
      if (push_page) wr_pg_q <= wr_pg_q + 1'b1;
      if (pop_done) begin
        if (rd_off_q == OW'(WORDS-1)) begin
          rd_off_q <= '0;
          rd_pg_q  <= rd_pg_q + 1'b1;
        end else begin
          rd_off_q <= rd_off_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spf_irq.sv
module spf_irq
  import spf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_empty,
  input  logic       lvl_full,
  input  logic       ovf_pulse,
  input  logic       cfg_wr,
  input  logic [5:0] cfg_wdata,
  output logic [5:0] reg_out,
  output logic       irq_any,
  output ev_vec_t    set_evt
);
  logic    empty_prev_q, full_prev_q;
  ev_vec_t status_q, mask_q, raw_evt, clr_vec;

  function automatic ev_vec_t next_status(input ev_vec_t cur, input ev_vec_t clr, input ev_vec_t set);
    return (cur & ~clr) | set;
  endfunction

  always_comb begin
    raw_evt           = '0;
    raw_evt[EV_EMPTY] = lvl_empty && !empty_prev_q;
    raw_evt[EV_FULL]  = lvl_full && !full_prev_q;
    raw_evt[EV_OVF]   = ovf_pulse;
  end

  assign set_evt = raw_evt & mask_q;
  assign clr_vec = cfg_wr ? cfg_wdata[IRQ_EVENTS-1:0] : '0;
  assign reg_out = {mask_q, status_q};
  assign irq_any = |status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_prev_q <= 1'b1;
      full_prev_q  <= 1'b0;
      status_q     <= '0;
      mask_q       <= '0;
    end else begin
      empty_prev_q <= lvl_empty;
      full_prev_q  <= lvl_full;
      status_q     <= next_status(status_q, clr_vec, set_evt);
      if (cfg_wr) mask_q <= cfg_wdata[5:3];
    end
  end
endmodule

// File: rtl/spf_top.sv
module spf_top
  import spf_pkg::*;
#(
  parameter int PAGES = 32,
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int OW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [OW-1:0] wr_off,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic          rd_strobe,
  output logic [DW-1:0] rd_data,
  output logic          data_req,
  output logic          fifo_empty,
  output logic          fifo_full,
  input  logic          ovf_evt,
  input  logic          cfg_wr,
  input  logic [5:0]    cfg_wdata,
  output logic [5:0]    irq_reg,
  output logic          irq
);
  logic [WORDS-1:0][DW-1:0] page_view;
  logic    commit_ok;
  logic    pop_done;
  ev_vec_t set_evt;

  assign commit_ok = commit && !fifo_full;
  assign data_req  = !fifo_empty;

  spf_open_page #(.WORDS(WORDS), .DW(DW)) open_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .clear(commit_ok), .page_view(page_view)
  );

  spf_store #(.PAGES(PAGES), .WORDS(WORDS), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n), .push_page(commit_ok), .page_in(page_view),
    .pop_req(rd_strobe), .head_word(rd_data), .is_empty(fifo_empty),
    .is_full(fifo_full), .pop_done(pop_done)
  );

  spf_irq irq_i (
    .clk(clk), .rst_n(rst_n), .lvl_empty(fifo_empty), .lvl_full(fifo_full),
    .ovf_pulse(ovf_evt), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .reg_out(irq_reg), .irq_any(irq), .set_evt(set_evt)
  );
endmodule

// File: rtl/spf_checker.sv
module spf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       commit,
  input logic       rd_strobe,
  input logic       cfg_wr,
  input logic [5:0] cfg_wdata,
  input logic       fifo_empty,
  input logic       fifo_full,
  input logic [5:0] irq_reg,
  input logic [2:0] set_evt
);
  AST_NOT_EMPTY_AND_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_empty && fifo_full)); // R7
  AST_COMMIT_SHOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !fifo_full |=> !fifo_empty); // R3
  AST_FULL_COMMIT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    commit && fifo_full && !rd_strobe |=> fifo_full); // R7
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty && !commit |=> fifo_empty); // R6
  AST_EMPTY_BIT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_reg[0]) |-> $past(irq_reg[3])); // R9
  AST_OVF_BIT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_reg[2]) |-> $past(irq_reg[5])); // R9
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_wdata[2] && !set_evt[2] |=> !irq_reg[2]); // R10
endmodule

bind spf_top spf_checker chk_i (
  .clk(clk), .rst_n(rst_n), .commit(commit), .rd_strobe(rd_strobe),
  .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .fifo_empty(fifo_empty),
  .fifo_full(fifo_full), .irq_reg(irq_reg), .set_evt(set_evt)
);

// File: tb/spf_top_tb_top.sv
module spf_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPAGES = 32;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, commit, rd_strobe, ovf_evt, cfg_wr;
  logic [2:0]  wr_off;
  logic [31:0] wr_data, rd_data;
  logic [5:0]  cfg_wdata, irq_reg;
  logic        data_req, fifo_empty, fifo_full, irq;
  int checks = 0;
  int errors = 0;

  // vector: {seed, write in reverse order, overwrite each offset}
  localparam logic [33:0] VEC [0:3] = '{
    {32'h1000_0000, 1'b0, 1'b0},
    {32'hA5A5_0000, 1'b1, 1'b0},
    {32'h0F0F_F0F0, 1'b0, 1'b1},
    {32'h7654_3210, 1'b1, 1'b1}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  spf_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .commit(commit), .rd_strobe(rd_strobe), .rd_data(rd_data), .data_req(data_req),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .ovf_evt(ovf_evt),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .irq_reg(irq_reg), .irq(irq)
  );

  function automatic logic [31:0] exp_word(input logic [31:0] seed, input int i);
    return seed + 32'(i) * 32'h0101_0011;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; commit = 0; rd_strobe = 0; ovf_evt = 0; cfg_wr = 0;
  endtask

  task automatic put(input int off, input logic [31:0] d);
    wr_en = 1; wr_off = 3'(off); wr_data = d;
    step();
  endtask

  task automatic do_commit();
    commit = 1;
    step();
  endtask

  task automatic pop();
    rd_strobe = 1;
    step();
  endtask

  task automatic cfg(input logic [5:0] d);
    cfg_wr = 1; cfg_wdata = d;
    step();
  endtask

  task automatic do_reset();
    rst_n = 0;
    step(); step();
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wr_en = 0; commit = 0; rd_strobe = 0; ovf_evt = 0; cfg_wr = 0;
    wr_off = 0; wr_data = 0; cfg_wdata = 0; rst_n = 0;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 empty", 32'(fifo_empty), 1);
    chk("R1 full", 32'(fifo_full), 0);
    chk("R1 req", 32'(data_req), 0);
    chk("R1 irq_reg", 32'(irq_reg), 0);
    chk("R1 irq", 32'(irq), 0);

    // table of pages walked by one loop
    for (int v = 0; v < 4; v++) begin
      logic [31:0] seed;
      seed = VEC[v][33:2];
      for (int k = 0; k < 8; k++) begin
        int o;
        o = VEC[v][1] ? 7 - k : k;
        if (VEC[v][0]) put(o, 32'hDEAD_0000 + 32'(o)); // R4 replaced below
        put(o, exp_word(seed, o));
      end
      chk("R3 no data before commit", 32'(data_req), 0);
      do_commit();
      chk("R3 req after commit", 32'(data_req), 1);
      for (int i = 0; i < 8; i++) begin
        chk((VEC[v][0]) ? "R4 overwrite order" : "R2 word order", rd_data, exp_word(seed, i));
        pop();
      end
      chk("R6 empty after drain", 32'(fifo_empty), 1);
    end

    // R6 pop on empty ignored; R5 commit-with-write merges and cleared page
    pop();
    commit = 1; wr_en = 1; wr_off = 3; wr_data = 32'h0000_0077;
    step();
    chk("R5 cleared offset", rd_data, 0);
    pop(); pop(); pop();
    chk("R2 same-cycle write committed", rd_data, 32'h77);

    // R7/R8 fill, full drop, retained page
    do_reset();
    cfg(6'b111_000);
    for (int p = 0; p < NPAGES; p++) begin
      for (int w = 0; w < 7; w++) put(w, {16'(p), 16'(w)});
      wr_en = 1; wr_off = 7; wr_data = {16'(p), 16'h7};
      do_commit();
    end
    chk("R7 full", 32'(fifo_full), 1);
    step();
    chk("R9 full bit", 32'(irq_reg[1]), 1);
    chk("R11 irq", 32'(irq), 1);
    cfg(6'b111_010);
    chk("R10 w1c full bit", 32'(irq_reg[1]), 0);
    put(0, 32'hDEAD_BEEF);
    do_commit();
    chk("R7 full after drop", 32'(fifo_full), 1);
    for (int i = 0; i < 7; i++) pop();
    chk("R8 full until last word", 32'(fifo_full), 1);
    pop();
    chk("R8 slot freed", 32'(fifo_full), 0);
    do_commit();
    chk("R7 retained page committed", 32'(fifo_full), 1);
    for (int p = 1; p < NPAGES; p++) begin
      for (int w = 0; w < 8; w++) begin
        if (w == 5) chk("R2 page order", rd_data, {16'(p), 16'h5});
        pop();
      end
    end
    chk("R7 retained word0", rd_data, 32'hDEAD_BEEF);
    pop();
    chk("R5 retained page other word", rd_data, 0);
    for (int i = 0; i < 7; i++) pop();
    chk("R6 empty", 32'(fifo_empty), 1);
    step();
    chk("R9 empty bit", 32'(irq_reg[0]), 1);

    // R9/R10/R11 overflow masking and clearing
    cfg(6'b000_111);
    chk("R10 clear all", 32'(irq_reg), 0);
    chk("R11 irq low", 32'(irq), 0);
    ovf_evt = 1; step();
    chk("R9 masked ovf", 32'(irq_reg[2]), 0);
    cfg(6'b100_000);
    ovf_evt = 1; step();
    chk("R9 ovf latched", 32'(irq_reg[2]), 1);
    chk("R11 irq high", 32'(irq), 1);
    cfg(6'b100_000);
    chk("R10 zero no effect", 32'(irq_reg[2]), 1);
    cfg(6'b100_100);
    chk("R10 w1c ovf", 32'(irq_reg[2]), 0);
    chk("R11 irq cleared", 32'(irq), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule